// File: doc/BRIEF.md
# Two-Bus Parallel/Serial Storage Register

This block is a register of WIDTH stages (eight by default) that sits between two parallel data buses, called A and B, and that also takes a single-bit serial input. Four control inputs set its operation. `par_mode` selects serial shifting or parallel transfer. `dir_a2b` sets which bus is the source and which one is driven. `async_xfer` makes a parallel transfer transparent, so that it does not wait for a clock edge. `a_enable` gates the A bus. Setting `a_enable` low while data flows from A to B makes every stage reload its own value. This recirculation holds the stored word.

Each bus is modelled as an input vector, an output vector and an output-enable, not as tri-state pins. A bus that is not driven shows zero on its output vector. The last stage is brought out as `ser_out` so that registers can be chained. The transparent parallel transfer is built as a combinational bypass in front of the flops. While the bypass is active, the selected source bus appears on the driven bus in the same cycle. The flops also capture it on every rising edge, so the value is kept after `async_xfer` returns low.

Top module: `bus_xfer_reg`

## Requirements
- R1: In serial mode (`par_mode`=0), each rising edge loads `ser_in` into stage 0 and moves stage i into stage i+1. `ser_out` always equals the top stage (bit WIDTH-1).
- R2: In serial mode, `async_xfer` has no effect. The stored word and the driven bus change only on a rising edge, even while `ser_in` changes with `async_xfer`=1.
- R3: `dir_a2b`=1 makes A the source and B the driven bus (`b_oe`=1, `a_oe`=0). `dir_a2b`=0 makes B the source, and A is driven only when `a_enable`=1. At most one of `a_oe` and `b_oe` is ever high.
- R4: In parallel mode with `async_xfer`=0, the source bus is captured on the rising edge. Until that edge, the driven bus shows the previously stored word.
- R5: In parallel mode with `async_xfer`=1, the driven bus shows the source bus in the same cycle, without waiting for a clock edge. The flops capture that value on each rising edge, so it stays stored after `async_xfer` falls.
- R6: In parallel mode with `dir_a2b`=1 and `a_enable`=0, the stored word holds through any number of clock edges, whatever value `a_in` has. This applies with `async_xfer` at either level.
- R7: In serial mode, the stored word is driven on B when `dir_a2b`=1. It is driven on A when `dir_a2b`=0 and `a_enable`=1. When `dir_a2b`=0 and `a_enable`=0, neither bus is driven.
- R8: With `a_enable`=0, `a_oe` is 0, `a_out` is all zeros, and `a_in` has no influence on the stored word.
- R9: A bus whose output-enable is 0 shows all zeros on its output vector. A driven bus shows the register's visible word.
- R10: Reset is synchronous and active low. A rising edge with `rst_n`=0 clears every stage, and both output-enables are 0 while `rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| par_mode | input | 1 | 1 = parallel transfer, 0 = serial shift |
| dir_a2b | input | 1 | 1 = A is the source and B is driven; 0 = B is the source |
| async_xfer | input | 1 | 1 = transparent parallel transfer (parallel mode only) |
| a_enable | input | 1 | Enables the A bus as source or as driven bus |
| ser_in | input | 1 | Serial data into stage 0 |
| a_in | input | WIDTH | A bus input value |
| a_out | output | WIDTH | A bus driven value (zero when not enabled) |
| a_oe | output | 1 | A bus output-enable |
| b_in | input | WIDTH | B bus input value |
| b_out | output | WIDTH | B bus driven value (zero when not enabled) |
| b_oe | output | 1 | B bus output-enable |
| ser_out | output | 1 | Top stage, used for chaining registers |

## Verification
A stage holding a wrong value is not visible on its own. It shows only when a bus is driven. The bench therefore reads the stored word back by switching to recirculation with B driven, one cycle after each transfer, so a bad capture shows on `b_out` within one clock. A fault in the bypass path shows on the driven bus in the same cycle as the input change, without any clock. A wrong enable decode shows at once on `a_oe` and `b_oe` for the control row concerned, and all twelve rows are covered.

// File: rtl/bxr_pkg.sv
// Package: shared types for the two-bus storage register.
// Assumes: no other definitions are needed by the submodules.
package bxr_pkg;

    // Where the next stored word comes from.
    typedef enum logic [1:0] {
        SRC_SHIFT = 2'd0,
        SRC_A     = 2'd1,
        SRC_B     = 2'd2,
        SRC_HOLD  = 2'd3
    } src_sel_e;

    // Decoded control word passed from the decoder to the datapath.
    typedef struct packed {
        src_sel_e src;
        logic     bypass;
        logic     a_oe;
        logic     b_oe;
    } ctrl_t;

endpackage

// File: rtl/bxr_ctrl.sv
// Module: bxr_ctrl
// Decodes the four mode inputs into a source select, a bypass flag and
// the two bus enables. Purely combinational.
// Assumes: the inputs are stable around the clock edge; rst_n low forces
// both enables off.
module bxr_ctrl
    import bxr_pkg::*;
(
    input  logic  rst_n,
    input  logic  par_mode,
    input  logic  dir_a2b,
    input  logic  async_xfer,
    input  logic  a_enable,
    output ctrl_t ctrl
);

    // Map the control inputs onto the source select, bypass and enables.
    always_comb begin
        ctrl = '0;
        if (!par_mode) begin
            ctrl.src    = SRC_SHIFT;
            ctrl.bypass = 1'b0;
        end else if (dir_a2b) begin
            ctrl.src    = a_enable ? SRC_A : SRC_HOLD;
            ctrl.bypass = async_xfer;
        end else begin
            ctrl.src    = SRC_B;
            ctrl.bypass = async_xfer;
        end
        ctrl.b_oe = rst_n & dir_a2b;
        ctrl.a_oe = rst_n & ~dir_a2b & a_enable;
    end

endmodule

// File: rtl/bxr_stages.sv
// Module: bxr_stages
// The WIDTH storage flops, the next-state selection (shift, load from A,
// load from B, hold) and the transparent bypass that gives the visible word.
// Assumes: synchronous active-low reset; the bypass is only requested in
// parallel mode.
module bxr_stages
    import bxr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  src_sel_e         src,
    input  logic             bypass,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] store_q,
    output logic [WIDTH-1:0] view
);

    logic [WIDTH-1:0] shift_d;
    logic [WIDTH-1:0] next_d;

    // Per-stage shift input: stage 0 takes the serial bit, others the stage below.
    for (genvar i = 0; i < WIDTH; i++) begin : g_shift
        if (i == 0) begin : g_first
            assign shift_d[i] = ser_in;
        end else begin : g_rest
            assign shift_d[i] = store_q[i-1];
        end
    end

    // Choose the next stored word from the decoded source.
    always_comb begin
        unique case (src)
            SRC_SHIFT: next_d = shift_d;
            SRC_A:     next_d = a_in;
            SRC_B:     next_d = b_in;
            default:   next_d = store_q;
        endcase
    end

    // Storage flops with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= next_d;
        end
    end

    // Visible word: the source itself during a transparent transfer.
    always_comb begin
        view = bypass ? next_d : store_q;
    end

endmodule

// File: rtl/bxr_drive.sv
// Module: bxr_drive
// Presents the visible word on whichever bus is enabled; an undriven bus
// reads zero.
// Assumes: at most one enable is high at a time (the decoder ensures it).
module bxr_drive #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] view,
    input  logic             a_oe,
    input  logic             b_oe,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] b_out
);

    // Gate the visible word onto each bus by its enable.
    always_comb begin
        a_out = a_oe ? view : '0;
        b_out = b_oe ? view : '0;
    end

endmodule

// File: rtl/bus_xfer_reg.sv
// Module: bus_xfer_reg (top)
// Storage register between two parallel buses with a serial input. It
// supports synchronous and transparent parallel transfer, recirculation and
// A-bus gating.
// Assumes: a single clock; synchronous active-low reset.
module bus_xfer_reg
    import bxr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_mode,
    input  logic             dir_a2b,
    input  logic             async_xfer,
    input  logic             a_enable,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    output logic             ser_out
);

    ctrl_t            ctrl;
    logic [WIDTH-1:0] store_q;
    logic [WIDTH-1:0] view;

    bxr_ctrl u_ctrl (
        .rst_n      (rst_n),
        .par_mode   (par_mode),
        .dir_a2b    (dir_a2b),
        .async_xfer (async_xfer),
        .a_enable   (a_enable),
        .ctrl       (ctrl)
    );

    bxr_stages #(.WIDTH(WIDTH)) u_stages (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (ctrl.src),
        .bypass  (ctrl.bypass),
        .ser_in  (ser_in),
        .a_in    (a_in),
        .b_in    (b_in),
        .store_q (store_q),
        .view    (view)
    );

    bxr_drive #(.WIDTH(WIDTH)) u_drive (
        .view  (view),
        .a_oe  (ctrl.a_oe),
        .b_oe  (ctrl.b_oe),
        .a_out (a_out),
        .b_out (b_out)
    );

    // Bring the enables and the chaining tap out to the ports.
    assign a_oe    = ctrl.a_oe;
    assign b_oe    = ctrl.b_oe;
    assign ser_out = store_q[WIDTH-1];

endmodule

// File: rtl/bxr_checker.sv
// Module: bxr_checker
// Temporal properties for bus_xfer_reg, attached to it by bind.
// Assumes: it sees the top ports and the internal stored word.
module bxr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             par_mode,
    input logic             dir_a2b,
    input logic             async_xfer,
    input logic             a_enable,
    input logic             ser_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             ser_out,
    input logic [WIDTH-1:0] store_q
);

    // R1: serial mode shifts one stage per edge.
    p_serial_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !par_mode |=> store_q == {$past(store_q[WIDTH-2:0]), $past(ser_in)});

    // R1: the chaining tap follows the top stage.
    p_tap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out == store_q[WIDTH-1]);

    // R3: never both buses driven.
    p_one_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_oe, b_oe}));

    // R5: transparent B-to-A transfer shows b_in on A at once.
    p_async_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (par_mode && async_xfer && !dir_a2b && a_enable) |-> a_out == b_in);

    // R6: recirculation keeps the stored word.
    p_recirc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (par_mode && dir_a2b && !a_enable) |=> $stable(store_q));

    // R8: disabled A bus stays silent.
    p_a_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !a_enable |-> (!a_oe && a_out == '0));

    // R9: an undriven B bus reads zero.
    p_b_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !b_oe |-> b_out == '0);

    // R10: reset clears the stages and keeps both buses off.
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> store_q == '0);
    p_reset_oe_r10: assert property (@(posedge clk)
        !rst_n |-> (!a_oe && !b_oe));

endmodule

bind bus_xfer_reg bxr_checker #(.WIDTH(WIDTH)) u_bxr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_mode   (par_mode),
    .dir_a2b    (dir_a2b),
    .async_xfer (async_xfer),
    .a_enable   (a_enable),
    .ser_in     (ser_in),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_in       (b_in),
    .b_out      (b_out),
    .b_oe       (b_oe),
    .ser_out    (ser_out),
    .store_q    (store_q)
);

// File: tb/bus_xfer_reg_bench.sv
// Bench for bus_xfer_reg: a walk over the twelve control rows, then directed
// tests for reset, serial shifting, transparent transfer and recirculation.
module bus_xfer_reg_bench;

    localparam int W = 8;

    // Row bits: {a_enable, par_mode, dir_a2b, async_xfer, exp a_oe, exp b_oe}
    localparam logic [5:0] VEC [12] = '{
        6'b000000, 6'b001001, 6'b010000, 6'b010100, 6'b011001, 6'b011101,
        6'b100010, 6'b101001, 6'b110010, 6'b110110, 6'b111001, 6'b111101
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         par_mode = 1'b0, dir_a2b = 1'b0, async_xfer = 1'b0, a_enable = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, ser_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bus_xfer_reg #(.WIDTH(W)) u_bus_xfer_reg (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .dir_a2b(dir_a2b),
        .async_xfer(async_xfer), .a_enable(a_enable), .ser_in(ser_in),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out),
        .b_oe(b_oe), .ser_out(ser_out)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic aen, input logic par, input logic dir,
                            input logic asy);
        a_enable = aen; par_mode = par; dir_a2b = dir; async_xfer = asy;
    endtask

    // One rising edge, then wait until the falling edge to drive or sample.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Store a word through a synchronous B-to-register load.
    task automatic preload(input logic [W-1:0] v);
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
        b_in = v;
        tick();
    endtask

    // Show the stored word on B through recirculation (changes nothing).
    task automatic readback(output logic [W-1:0] v);
        set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
        #1;
        v = b_out;
    endtask

    logic [W-1:0] rd;

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        rst_n = 1'b0;
        set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
        #1;
        // R10: enables are off while reset is held
        check(!a_oe && !b_oe, "R10 oe during reset", {6'b0, a_oe, b_oe}, '0);
        tick();
        rst_n = 1'b1;
        readback(rd);
        check(rd == '0, "R10 cleared word", rd, '0);

        // Walk the control table (R3, R4, R5, R6, R7, R8, R9)
        for (int r = 0; r < 12; r++) begin
            logic [W-1:0] p, a, b, src, vis, st;
            logic aen, par, dir, asy, s;
            p = W'(8'h3C + r * 17);
            a = W'(8'hA5 ^ (r * 7));
            b = W'(8'h81 + r * 29);
            s = r[0];
            {aen, par, dir, asy} = VEC[r][5:2];
            preload(p);
            a_in = a; b_in = b; ser_in = s;
            set_ctrl(aen, par, dir, asy);
            #1;
            src = dir ? (aen ? a : p) : b;
            vis = (par && asy) ? src : p;
            st  = par ? src : {p[W-2:0], s};
            check({a_oe, b_oe} == VEC[r][1:0], $sformatf("R3/R7 row %0d enables", r),
                  {6'b0, a_oe, b_oe}, {6'b0, VEC[r][1:0]});
            check(a_out == (VEC[r][1] ? vis : '0), $sformatf("R9/R8 row %0d a_out", r),
                  a_out, VEC[r][1] ? vis : '0);
            check(b_out == (VEC[r][0] ? vis : '0), $sformatf("R9/R4/R5 row %0d b_out", r),
                  b_out, VEC[r][0] ? vis : '0);
            tick();
            readback(rd);
            check(rd == st, $sformatf("R6/R4 row %0d stored", r), rd, st);
        end

        // R1: shift a pattern in serially and watch the tap
        begin
            logic [W-1:0] pat;
            pat = 8'b1011_0010;
            preload('0);
            set_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
            for (int i = W - 1; i >= 0; i--) begin
                ser_in = pat[i];
                tick();
            end
            check(b_out == pat, "R1 serial word", b_out, pat);
            check(ser_out == pat[W-1], "R1 tap", {7'b0, ser_out}, {7'b0, pat[W-1]});
        end

        // R2: serial mode with async_xfer high does not change before an edge
        preload(8'h5A);
        set_ctrl(1'b0, 1'b0, 1'b1, 1'b1);
        ser_in = 1'b1;
        #1;
        check(b_out == 8'h5A, "R2 no async serial", b_out, 8'h5A);
        ser_in = 1'b0;
        #1;
        check(b_out == 8'h5A, "R2 still unchanged", b_out, 8'h5A);
        tick();
        check(b_out == 8'hB4, "R2 shift on edge", b_out, 8'hB4);

        // R5: transparent A-to-B follows a_in with no edge, kept afterwards
        preload(8'h00);
        set_ctrl(1'b1, 1'b1, 1'b1, 1'b1);
        a_in = 8'hC3;
        #1;
        check(b_out == 8'hC3, "R5 transparent 1", b_out, 8'hC3);
        a_in = 8'h3E;
        #1;
        check(b_out == 8'h3E, "R5 transparent 2", b_out, 8'h3E);
        tick();
        async_xfer = 1'b0;
        a_in = 8'h00;
        #1;
        check(b_out == 8'h3E, "R5 kept after async low", b_out, 8'h3E);

        // R6 / R8: recirculation ignores a_in across several edges
        preload(8'h96);
        set_ctrl(1'b0, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 4; k++) begin
            a_in = W'(k * 37 + 1);
            tick();
        end
        readback(rd);
        check(rd == 8'h96, "R6 hold over edges", rd, 8'h96);
        check(a_out == '0 && !a_oe, "R8 A silent", a_out, '0);

        // R10: reset in mid-operation clears the word
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        readback(rd);
        check(rd == '0, "R10 mid-run clear", rd, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule